// File: doc/BRIEF.md
# Stack Burst Sequencer

This block carries out one push-several or pull-several instruction for a 32-bit processor. It breaks that instruction into single-word stack transfers. A 4-bit selection field names the words to move: the accumulator, the two index registers and a constant carried in the instruction's 24-bit operand. The selection field does not set the order. The hardware always moves the words in the same order, and a pull visits them in the reverse of a push, so a pull with the same selection undoes a push.

The core raises `start` for one cycle while `busy` is low. With that strobe it presents the direction, the selection field, the operand, the three register values and the current stack pointer. The block keeps its own copy of these values and then runs through one base cycle followed by a two-cycle slot for each selected word. In the first cycle of a slot it drives the memory port. In the second cycle it moves the stack pointer (push) or hands the read word back to the core (pull). `done` is high during the last busy cycle. `sp_out` holds the final pointer from the following cycle on.

The memory port is a plain single-cycle synchronous port. There is no valid/ready pair because the port never stalls. A write happens at the clock edge that ends a cycle with `mem_we` high. Read data must be on `mem_rdata` during the cycle after `mem_re`. The control pins are plain strobes. `start` while busy is dropped rather than held back, so the core must wait for `busy` to be low before issuing a new instruction.

Top module: `stack_burst_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we`, `mem_re` and `ld_sel` are all low.
- R2: `start` is accepted only while `busy` is low. A `start` during an operation changes neither that operation's accesses, its length nor its final pointer, and does not begin a new operation.
- R3: An accepted operation keeps `busy` high for 1 + 2·n cycles, where n is the number of words it moves. `done` is high only in the last of those cycles, and `busy` is low in the next.
- R4: A push writes the selected words in the fixed order constant (mask bit 3), Y (bit 2), X (bit 1), A (bit 0), whatever the mask pattern.
- R5: A pull reads in the order A, X, Y. Mask bit 3 has no effect on a pull: no extra access and no extra cycles.
- R6: Each push write goes to the current pointer value, and the pointer then drops by one. After a push of n words, `sp_out` equals the start pointer minus n.
- R7: Each pull first steps the pointer up by one and reads from that address. After a pull of n words, `sp_out` equals the start pointer plus n.
- R8: The pushed constant is the 24-bit operand sign-extended to 32 bits.
- R9: A mask with no selected word (for a pull, none of bits 0 to 2) finishes in exactly one cycle with `done` high and no memory access.
- R10: Each pulled word appears on `ld_data` in the second cycle of its slot, with `ld_sel` one-hot naming the target: bit 0 A, bit 1 X, bit 2 Y.
- R11: `mem_we` and `mem_re` are never high together. A memory access is never followed directly by another in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| pull | input | 1 | 0 = push, 1 = pull |
| mask | input | 4 | Word selection: bit0 A, bit1 X, bit2 Y, bit3 constant |
| operand | input | 24 | Instruction operand, pushed as a constant |
| reg_a | input | 32 | Accumulator value |
| reg_x | input | 32 | X index value |
| reg_y | input | 32 | Y index value |
| sp_in | input | 32 | Stack pointer at start |
| sp_out | output | 32 | Working / final stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of the operation |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_re` |
| ld_sel | output | 3 | One-hot register load select on a pull |
| ld_data | output | 32 | Word to load into the selected register |

## Verification
Push and pull are each driven with the full mask, with single-bit masks and with random subsets. Comparing the write sequence against the fixed order separates a correct priority encoder from one that follows bit order or reverses direction. Constants with the top operand bit set and clear tell sign extension apart from zero extension. Pushes followed by pulls of the same mask confirm that the pull order is the exact inverse. Empty masks, a pull with only the constant bit set, and a `start` pulsed in the middle of an operation separate the base-cycle path and the ignore rules from an operation that runs extra slots or restarts.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

  localparam int NSRC  = 4;   // A, X, Y, constant
  localparam int NREG  = 3;   // loadable registers on a pull
  localparam int SRC_K = 3;   // index of the constant source

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_ADDR = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/stkseq_pick.sv
module stkseq_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] pend,
  input  logic         low_first,
  output logic [N-1:0] pick
);

  logic [N-1:0] pick_hi;
  logic [N-1:0] pick_lo;

  // highest pending bit
  always_comb begin
    pick_hi = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) pick_hi = N'(1) << i;
    end
  end

  // lowest pending bit
  always_comb begin
    pick_lo = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) pick_lo = N'(1) << i;
    end
  end

  assign pick = low_first ? pick_lo : pick_hi;

endmodule

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl
  import stkseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            pull,
  input  logic [NSRC-1:0] mask,
  output logic            accept,
  output seq_state_e      state,
  output logic            pull_q,
  output logic [NSRC-1:0] cur_oh,
  output logic            busy,
  output logic            done
);

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] pick;
  logic [NSRC-1:0] start_mask;
  logic [NSRC-1:0] above_cur;

  stkseq_pick #(.N(NSRC)) u_pick (
    .pend      (pend),
    .low_first (pull_q),
    .pick      (pick)
  );

  assign accept = (state == ST_IDLE) && start;

  // the constant source never takes part in a pull
  always_comb begin
    start_mask = mask;
    if (pull) start_mask[SRC_K] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pend   <= '0;
      pull_q <= 1'b0;
      cur_oh <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            pend   <= start_mask;
            pull_q <= pull;
            state  <= ST_BASE;
          end
        end
        ST_BASE, ST_FIN: begin
          if (pend == '0) begin
            cur_oh <= '0;
            state  <= ST_IDLE;
          end else begin
            cur_oh <= pick;
            pend   <= pend & ~pick;
            state  <= ST_ADDR;
          end
        end
        ST_ADDR: state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = ((state == ST_BASE) || (state == ST_FIN)) && (pend == '0);

  assign above_cur = ~((cur_oh << 1) - NSRC'(1));

  // exactly one source is active during each access cycle
  assert_one_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR) |-> ($countones(cur_oh) == 1));

  // push: nothing still pending ranks above the word being moved
  assert_push_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && !pull_q) |-> ((pend & above_cur) == '0));

  // pull: nothing still pending ranks below the word being moved
  assert_pull_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && pull_q) |-> ((pend & ~above_cur & ~cur_oh) == '0));

  // pull never carries the constant source
  assert_pull_no_const_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pull_q) |-> (!pend[SRC_K] && !cur_oh[SRC_K]));

  // the cycle after done is idle
  assert_done_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // a start during an operation does not disturb the slot sequence
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && start) |=> (state == ST_FIN && $stable(pull_q)));

endmodule

// File: rtl/stkseq_dpath.sv
module stkseq_dpath
  import stkseq_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 32,
  parameter int IMW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  seq_state_e      state,
  input  logic            pull_q,
  input  logic [NSRC-1:0] cur_oh,
  input  logic [IMW-1:0]  operand,
  input  logic [DW-1:0]   reg_a,
  input  logic [DW-1:0]   reg_x,
  input  logic [DW-1:0]   reg_y,
  input  logic [AW-1:0]   sp_in,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   sp_out,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic [NREG-1:0] ld_sel,
  output logic [DW-1:0]   ld_data
);

  localparam int EXT_W = DW - IMW;

  logic [AW-1:0]  sp_q;
  logic [DW-1:0]  src [NSRC];
  logic [DW-1:0]  a_q, x_q, y_q;
  logic [IMW-1:0] imm_q;
  logic [DW-1:0]  word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      a_q   <= '0;
      x_q   <= '0;
      y_q   <= '0;
      imm_q <= '0;
    end else if (accept) begin
      sp_q  <= sp_in;
      a_q   <= reg_a;
      x_q   <= reg_x;
      y_q   <= reg_y;
      imm_q <= operand;
    end else if (state == ST_FIN) begin
      sp_q <= pull_q ? (sp_q + AW'(1)) : (sp_q - AW'(1));
    end
  end

  assign src[0]     = a_q;
  assign src[1]     = x_q;
  assign src[2]     = y_q;
  assign src[SRC_K] = {{EXT_W{imm_q[IMW-1]}}, imm_q};

  always_comb begin
    word = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cur_oh[i]) word = word | src[i];
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (state == ST_ADDR) begin
      if (pull_q) begin
        mem_re   = 1'b1;
        mem_addr = sp_q + AW'(1);
      end else begin
        mem_we    = 1'b1;
        mem_addr  = sp_q;
        mem_wdata = word;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_ld
      assign ld_sel[g] = (state == ST_FIN) && pull_q && cur_oh[g];
    end
  endgenerate

  assign ld_data = (ld_sel != '0) ? mem_rdata : '0;
  assign sp_out  = sp_q;

  assert_no_rw_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_access_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> !(mem_we || mem_re));

  assert_push_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ##1 (sp_out == $past(mem_addr, 2) - AW'(1)));

  assert_pull_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ##1 (sp_out == $past(mem_addr, 2)));

  assert_load_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ($countones(ld_sel) == 1));

  assert_load_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_sel));

endmodule

// File: rtl/stack_burst_seq.sv
module stack_burst_seq
  import stkseq_pkg::*;
#(
  parameter int DW  = 32,
  parameter int AW  = 32,
  parameter int IMW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            pull,
  input  logic [3:0]      mask,
  input  logic [IMW-1:0]  operand,
  input  logic [DW-1:0]   reg_a,
  input  logic [DW-1:0]   reg_x,
  input  logic [DW-1:0]   reg_y,
  input  logic [AW-1:0]   sp_in,
  output logic [AW-1:0]   sp_out,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2:0]      ld_sel,
  output logic [DW-1:0]   ld_data
);

  logic            accept;
  seq_state_e      state;
  logic            pull_q;
  logic [NSRC-1:0] cur_oh;

  stkseq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .pull   (pull),
    .mask   (mask),
    .accept (accept),
    .state  (state),
    .pull_q (pull_q),
    .cur_oh (cur_oh),
    .busy   (busy),
    .done   (done)
  );

  stkseq_dpath #(.DW(DW), .AW(AW), .IMW(IMW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .state     (state),
    .pull_q    (pull_q),
    .cur_oh    (cur_oh),
    .operand   (operand),
    .reg_a     (reg_a),
    .reg_x     (reg_x),
    .reg_y     (reg_y),
    .sp_in     (sp_in),
    .mem_rdata (mem_rdata),
    .sp_out    (sp_out),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .ld_sel    (ld_sel),
    .ld_data   (ld_data)
  );

  // an empty selection ends in the base cycle without touching memory
  assert_empty_is_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(busy)) |-> (!mem_we && !mem_re));

endmodule

// File: tb/stack_burst_seq_tb.sv
module stack_burst_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pull = 1'b0;
  logic [3:0]  mask = '0;
  logic [23:0] operand = '0;
  logic [31:0] reg_a = '0, reg_x = '0, reg_y = '0, sp_in = '0;
  logic [31:0] sp_out, mem_addr, mem_wdata, mem_rdata, ld_data;
  logic        busy, done, mem_we, mem_re;
  logic [2:0]  ld_sel;

  logic [31:0] mem [256];
  logic [31:0] rdq;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;  // 50 MHz

  stack_burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pull(pull), .mask(mask),
    .operand(operand), .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
    .sp_in(sp_in), .sp_out(sp_out), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .ld_sel(ld_sel), .ld_data(ld_data)
  );

  function automatic logic [31:0] seed_word(int i);
    return (32'(i) * 32'h0101_0107) ^ 32'hA5C3_5A3C;
  endfunction

  function automatic logic [31:0] sext24(logic [23:0] v);
    return {{8{v[23]}}, v};
  endfunction

  // single-cycle synchronous memory model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed_word(i);
      rdq <= '0;
    end else begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) rdq <= mem[mem_addr[7:0]];
    end
  end
  assign mem_rdata = rdq;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic run_op(input logic dir, input logic [3:0] m, input logic [23:0] imm,
                        input logic [31:0] a, input logic [31:0] x, input logic [31:0] y,
                        input logic [31:0] sp0, input bit poke);
    logic [31:0] ew_a [4];
    logic [31:0] ew_d [4];
    logic [2:0]  el_s [4];
    logic [31:0] el_d [4];
    logic [31:0] vals [4];
    int n, cyc, nw, nl, nr;
    n = 0; cyc = 0; nw = 0; nl = 0; nr = 0;
    vals[0] = a; vals[1] = x; vals[2] = y; vals[3] = sext24(imm);
    if (!dir) begin
      for (int b = 3; b >= 0; b--) if (m[b]) begin
        ew_a[n] = sp0 - 32'(n);
        ew_d[n] = vals[b];
        n++;
      end
    end else begin
      for (int b = 0; b < 3; b++) if (m[b]) begin
        el_s[n] = 3'(1 << b);
        el_d[n] = mem[8'(sp0 + 32'(n) + 1)];
        n++;
      end
    end
    @(negedge clk);
    start = 1'b1; pull = dir; mask = m; operand = imm;
    reg_a = a; reg_x = x; reg_y = y; sp_in = sp0;
    @(negedge clk);
    start = 1'b0;
    forever begin
      cyc++;
      if (mem_re) nr++;
      if (mem_we) begin
        if (dir || nw >= n) chk(0, "R5 unexpected write", mem_addr, 32'h0);
        else begin
          chk(mem_addr == ew_a[nw], "R6 write address", mem_addr, ew_a[nw]);
          chk(mem_wdata == ew_d[nw], "R4/R8 write data order", mem_wdata, ew_d[nw]);
        end
        nw++;
      end
      if (ld_sel != 3'b000) begin
        if (!dir || nl >= n) chk(0, "R10 unexpected load", {29'd0, ld_sel}, 32'h0);
        else begin
          chk(ld_sel == el_s[nl], "R5/R10 load select order", {29'd0, ld_sel}, {29'd0, el_s[nl]});
          chk(ld_data == el_d[nl], "R7/R10 load data", ld_data, el_d[nl]);
        end
        nl++;
      end
      if (done || cyc > 40) break;
      if (poke && cyc == 1) begin
        start = 1'b1; mask = ~m; pull = ~dir; sp_in = sp0 + 32'd77;
      end
      @(negedge clk);
      start = 1'b0; mask = m; pull = dir; sp_in = sp0;
    end
    chk(cyc == 1 + 2 * n, "R3 duration", 32'(cyc), 32'(1 + 2 * n));
    if (dir) chk(nr == n && nw == 0, "R5 read count", 32'(nr), 32'(n));
    else     chk(nw == n && nr == 0, "R4 write count", 32'(nw), 32'(n));
    if (n == 0) chk(cyc == 1 && nr == 0 && nw == 0, "R9 empty mask", 32'(nr + nw), 32'h0);
    @(negedge clk);
    chk(!busy && !done, "R2/R3 idle after done", {30'd0, busy, done}, 32'h0);
    if (dir) chk(sp_out == sp0 + 32'(n), "R7 final pointer", sp_out, sp0 + 32'(n));
    else     chk(sp_out == sp0 - 32'(n), "R6 final pointer", sp_out, sp0 - 32'(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we && !mem_re && ld_sel == 3'b000, "R1 reset state",
        {27'd0, busy, done, mem_we, mem_re, |ld_sel}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", {30'd0, busy, done}, 32'h0);

    // R4 R8: full push, negative constant
    run_op(1'b0, 4'b1111, 24'h80_1234, 32'h1111_0001, 32'h2222_0002, 32'h3333_0003, 32'd120, 0);
    // R8: positive constant alone
    run_op(1'b0, 4'b1000, 24'h7F_FFFE, 32'h0, 32'h0, 32'h0, 32'd60, 0);
    // R5 R7: pull back A, X, Y of the first push (lands at 117..119)
    run_op(1'b1, 4'b0111, 24'h0, 32'h0, 32'h0, 32'h0, 32'd116, 0);
    // R5: constant bit ignored on pull
    run_op(1'b1, 4'b1111, 24'hFF_FFFF, 32'h0, 32'h0, 32'h0, 32'd30, 0);
    run_op(1'b1, 4'b1000, 24'h12_3456, 32'h0, 32'h0, 32'h0, 32'd31, 0);
    // R9: empty masks
    run_op(1'b0, 4'b0000, 24'h0, 32'h5, 32'h6, 32'h7, 32'd40, 0);
    run_op(1'b1, 4'b0000, 24'h0, 32'h0, 32'h0, 32'h0, 32'd41, 0);
    // R2: start pulsed while busy
    run_op(1'b0, 4'b0101, 24'h00_0042, 32'hAAAA_5555, 32'h0, 32'hCCCC_3333, 32'd200, 1);
    run_op(1'b1, 4'b0110, 24'h0, 32'h0, 32'h0, 32'h0, 32'd10, 1);

    for (int k = 0; k < 40; k++) begin
      logic [3:0]  rm;
      logic        rd;
      logic [31:0] rs;
      rm = 4'($urandom_range(0, 15));
      rd = 1'($urandom_range(0, 1));
      rs = 32'($urandom_range(8, 240));
      run_op(rd, rm, 24'($urandom), $urandom, $urandom, $urandom, rs,
             ($urandom_range(0, 3) == 0) && (rm[2:0] != 3'b000));
    end

    summary();
    $finish;
  end

endmodule